// File: doc/BRIEF.md
# Video Sync Timing Generator with Master and Slave Modes

This block is the timing core of a video encoder front end. It runs on a clock at twice the pixel rate and derives a pixel clock enable from it by dividing by two or by four. All timing counters advance only on that enable. In master mode the block generates its own horizontal sync, vertical sync, composite blanking and field signals from parameterised line and field geometry. The defaults are 858 pixels per line and fields of 263 lines (odd) and 262 lines (even).

In slave mode the block locks its counters to external horizontal and vertical sync inputs. Each input is first corrected for polarity, then only its leading edge is taken. An early horizontal sync cuts the current line short. A late one stretches the line by parking the counter in the front porch, and the output datapath sees this through a hold flag. Vertical sync works the same way, one line at a time: the counter parks on the last front-porch line with blanking asserted. In slave mode an external blanking input is also combined into the blanking output. Every sync, blank and field output has its own polarity control.

Top module: `vid_sync_timer`

## Requirements
- R1: `pix_en` is high for exactly one `clk2x` cycle in every 2 cycles when `div4_mode` is 0, and in every 4 cycles when it is 1. All counters advance only on cycles where `pix_en` is high.
- R2: While `rst_n` is low, `pix_en`, `fp_hold` and `blk_hold` are 0 and every sync, blank and field output sits at its inactive level. After release, the first pixel is pixel 0 of line 0 of the odd field.
- R3: In master mode a line lasts H_ACTIVE+H_FP+H_SYNC+H_BP pixels. Horizontal sync is active for H_SYNC pixels, starting at pixel H_ACTIVE+H_FP. Blanking is active on pixels at or beyond H_ACTIVE, and on every pixel of lines at or beyond V_ACTIVE.
- R4: In master mode vertical sync is active for V_SYNC whole lines, starting at line V_ACTIVE+V_FP. The even field lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines and the odd field one line more. The external sync and blank inputs have no effect.
- R5: The field signal starts at odd (internal value 0) and toggles on the pixel where vertical sync becomes active, in both modes. Internal value 1 means the even field.
- R6: In slave mode a leading edge on the external horizontal sync, sampled on a pixel enable, moves the horizontal counter to the sync start. The sync output therefore asserts on the following pixel, and a sync arriving early shortens the line.
- R7: In slave mode, if the counter reaches the last front-porch pixel and no horizontal sync edge has come, the counter holds there. `fp_hold` is high from the pixel where the sync would have started until the edge arrives, and the line becomes as long as the external sync period.
- R8: In slave mode the field period equals the external vertical sync period. If no vertical edge has come by the end of the last front-porch line, that line repeats, `blk_hold` is high and blanking stays active until the edge arrives.
- R9: Each output among horizontal sync, vertical sync, blank and field equals its internal active value XOR its polarity input (polarity 1 means active low). Each external input is interpreted through the same polarity bit as the output of the same kind.
- R10: Only a leading edge resynchronises. An external sync held active across many pixels causes a single resync, after which the counter waits in the front porch.
- R11: In slave mode the external blank input, sampled on a pixel enable, forces the blanking output active from the next pixel. When it is released, blanking follows the counters again from the next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = follow external syncs, 0 = generate timing |
| div4_mode | input | 1 | 1 = pixel enable every 4 cycles, 0 = every 2 |
| pol_hs | input | 1 | Horizontal sync polarity (1 = active low) |
| pol_vs | input | 1 | Vertical sync polarity |
| pol_blk | input | 1 | Blank polarity |
| pol_fld | input | 1 | Field polarity |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical sync |
| ext_blk | input | 1 | External composite blank |
| pix_en | output | 1 | Pixel clock enable |
| hs_out | output | 1 | Horizontal sync |
| vs_out | output | 1 | Vertical sync |
| blk_out | output | 1 | Composite blank |
| fld_out | output | 1 | Field indicator |
| fp_hold | output | 1 | Line stretched: outputs held at front porch |
| blk_hold | output | 1 | Field stretched: outputs held at blanking |

## Verification
The bench uses a miniature raster: 8 active pixels, a 2-pixel front porch, a 3-pixel sync and a 3-pixel back porch, giving 16-pixel lines. Vertically it has 4 active lines, 1 front-porch line, 2 sync lines and 2 back-porch lines, giving fields of 9 and 10 lines. With this geometry, whole fields of both parities, the odd/even alternation and the vertical stall in slave mode all fit into a few hundred pixels. Because the divide-by-two enable is used, every expected sync position and hold count can be worked out by hand in pixel units.

// File: rtl/vst_pkg.sv
package vst_pkg;
  // Bundle of the four timing outputs, reused for their polarity controls.
  typedef struct packed {
    logic hs;
    logic vs;
    logic blk;
    logic fld;
  } vst_sig_t;

  // External sync channels that carry an edge detector (hs, vs).
  localparam int EXT_SYNC_N = 2;
endpackage

// File: rtl/vst_clkdiv.sv
module vst_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  output logic pix_en
);
  logic [1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 2'd1;
  end

  // One-cycle enable: odd phases for /2, phase 3 only for /4.
  assign pix_en = div4 ? (&dcnt) : dcnt[0];
endmodule

// File: rtl/vst_lead_det.sv
module vst_lead_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic raw,
  input  logic pol,
  output logic lead
);
  logic corr, prev_q;

  assign corr = raw ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (pix_en) prev_q <= corr;
  end

  assign lead = pix_en & corr & ~prev_q;
endmodule

// File: rtl/vst_hcount.sv
module vst_hcount #(
  parameter int H_ACTIVE = 720,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 62,
  parameter int H_BP     = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic slave,
  input  logic hs_lead,
  output logic h_sync,
  output logic h_blank,
  output logic line_end,
  output logic fp_wait
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int SYNC_AT = H_ACTIVE + H_FP;
  localparam logic [HW-1:0] L_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] L_SYNC = HW'(SYNC_AT);
  localparam logic [HW-1:0] L_PRE  = HW'(SYNC_AT - 1);
  localparam logic [HW-1:0] L_SEND = HW'(SYNC_AT + H_SYNC);
  localparam logic [HW-1:0] L_ACT  = HW'(H_ACTIVE);

  logic [HW-1:0] hcnt;
  logic          wait_q;
  logic          resync, stall;

  assign resync = slave & hs_lead;
  assign stall  = slave & ~hs_lead & (hcnt == L_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      wait_q <= 1'b0;
    end else if (pix_en) begin
      if (resync) begin
        hcnt   <= L_SYNC;
        wait_q <= 1'b0;
      end else if (stall) begin
        wait_q <= 1'b1;
      end else begin
        wait_q <= 1'b0;
        hcnt   <= (hcnt == L_LAST) ? '0 : hcnt + 1'b1;
      end
    end
  end

  assign line_end = pix_en & ~resync & (hcnt == L_LAST);
  assign h_sync   = (hcnt >= L_SYNC) && (hcnt < L_SEND);
  assign h_blank  = (hcnt >= L_ACT);
  assign fp_wait  = wait_q;
endmodule

// File: rtl/vst_vcount.sv
module vst_vcount #(
  parameter int V_ACTIVE = 240,
  parameter int V_FP     = 3,
  parameter int V_SYNC   = 3,
  parameter int V_BP     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic slave,
  input  logic line_end,
  input  logic vs_lead,
  output logic v_sync,
  output logic v_blank,
  output logic field_even,
  output logic blk_wait
);
  localparam int V_EVEN  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int V_ODD   = V_EVEN + 1;
  localparam int VW      = $clog2(V_ODD);
  localparam int SYNC_AT = V_ACTIVE + V_FP;
  localparam logic [VW-1:0] L_SYNC = VW'(SYNC_AT);
  localparam logic [VW-1:0] L_PRE  = VW'(SYNC_AT - 1);
  localparam logic [VW-1:0] L_SEND = VW'(SYNC_AT + V_SYNC);
  localparam logic [VW-1:0] L_ACT  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] L_LE   = VW'(V_EVEN - 1);
  localparam logic [VW-1:0] L_LO   = VW'(V_ODD - 1);

  logic [VW-1:0] vcnt, last;
  logic          fld_q, wait_q;

  assign last = fld_q ? L_LE : L_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt   <= '0;
      fld_q  <= 1'b0;
      wait_q <= 1'b0;
    end else if (pix_en) begin
      if (!slave) wait_q <= 1'b0;
      if (slave && vs_lead) begin
        vcnt   <= L_SYNC;
        fld_q  <= ~fld_q;
        wait_q <= 1'b0;
      end else if (line_end) begin
        if (vcnt == L_PRE) begin
          if (slave) begin
            wait_q <= 1'b1;
          end else begin
            vcnt  <= L_SYNC;
            fld_q <= ~fld_q;
          end
        end else if (vcnt == last) begin
          vcnt <= '0;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end
    end
  end

  assign v_sync     = (vcnt >= L_SYNC) && (vcnt < L_SEND);
  assign v_blank    = (vcnt >= L_ACT);
  assign field_even = fld_q;
  assign blk_wait   = wait_q;
endmodule

// File: rtl/vid_sync_timer.sv
module vid_sync_timer
  import vst_pkg::*;
#(
  parameter int H_ACTIVE = 720,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 62,
  parameter int H_BP     = 60,
  parameter int V_ACTIVE = 240,
  parameter int V_FP     = 3,
  parameter int V_SYNC   = 3,
  parameter int V_BP     = 16
) (
  input  logic clk2x,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic div4_mode,
  input  logic pol_hs,
  input  logic pol_vs,
  input  logic pol_blk,
  input  logic pol_fld,
  input  logic ext_hs,
  input  logic ext_vs,
  input  logic ext_blk,
  output logic pix_en,
  output logic hs_out,
  output logic vs_out,
  output logic blk_out,
  output logic fld_out,
  output logic fp_hold,
  output logic blk_hold
);
  logic [EXT_SYNC_N-1:0] ext_raw, ext_pol, ext_lead;
  logic h_sync, h_blank, line_end, h_wait;
  logic v_sync, v_blank, fld_even, v_wait;
  logic blk_lvl;
  vst_sig_t act, pol;

  vst_clkdiv u_div (.clk(clk2x), .rst_n, .div4(div4_mode), .pix_en);

  assign ext_raw = {ext_vs, ext_hs};
  assign ext_pol = {pol_vs, pol_hs};

  for (genvar i = 0; i < EXT_SYNC_N; i++) begin : g_edge
    vst_lead_det u_det (
      .clk(clk2x), .rst_n, .pix_en,
      .raw(ext_raw[i]), .pol(ext_pol[i]), .lead(ext_lead[i])
    );
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)      blk_lvl <= 1'b0;
    else if (pix_en) blk_lvl <= ext_blk ^ pol_blk;
  end

  vst_hcount #(.H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP)) u_h (
    .clk(clk2x), .rst_n, .pix_en, .slave(slave_mode), .hs_lead(ext_lead[0]),
    .h_sync, .h_blank, .line_end, .fp_wait(h_wait)
  );

  vst_vcount #(.V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)) u_v (
    .clk(clk2x), .rst_n, .pix_en, .slave(slave_mode), .line_end, .vs_lead(ext_lead[1]),
    .v_sync, .v_blank, .field_even(fld_even), .blk_wait(v_wait)
  );

  assign act = '{hs: h_sync, vs: v_sync,
                 blk: h_blank | v_blank | (slave_mode & blk_lvl), fld: fld_even};
  assign pol = '{hs: pol_hs, vs: pol_vs, blk: pol_blk, fld: pol_fld};

  assign hs_out   = act.hs  ^ pol.hs;
  assign vs_out   = act.vs  ^ pol.vs;
  assign blk_out  = act.blk ^ pol.blk;
  assign fld_out  = act.fld ^ pol.fld;
  assign fp_hold  = h_wait & slave_mode;
  assign blk_hold = v_wait & slave_mode;
endmodule

// File: rtl/vst_checker.sv
module vst_checker (
  input logic clk,
  input logic rst_n,
  input logic pix_en,
  input logic pol_hs,
  input logic pol_vs,
  input logic pol_blk,
  input logic pol_fld,
  input logic hs_out,
  input logic vs_out,
  input logic blk_out,
  input logic fld_out,
  input logic fp_hold,
  input logic blk_hold
);
  a_r1_pix_en_single: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  a_r3_pixel_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hs_out) || !$stable(pol_hs)));

  a_r5_field_at_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fld_out) && $stable(pol_fld) && $stable(pol_vs)) |-> (vs_out != pol_vs));

  a_r7_fp_hold_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    fp_hold |-> (blk_out != pol_blk));

  a_r8_blk_hold_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hold |-> (blk_out != pol_blk));
endmodule

bind vid_sync_timer vst_checker u_chk (
  .clk(clk2x), .rst_n(rst_n), .pix_en(pix_en),
  .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_blk(pol_blk), .pol_fld(pol_fld),
  .hs_out(hs_out), .vs_out(vs_out), .blk_out(blk_out), .fld_out(fld_out),
  .fp_hold(fp_hold), .blk_hold(blk_hold)
);

// File: tb/tb_vid_sync_timer.sv
`timescale 1ns/1ps
module tb_vid_sync_timer;
  localparam int HT = 16;

  logic clk2x = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0, div4_mode = 1'b0;
  logic pol_hs = 1'b0, pol_vs = 1'b0, pol_blk = 1'b0, pol_fld = 1'b0;
  logic ext_hs = 1'b0, ext_vs = 1'b0, ext_blk = 1'b0;
  logic pix_en, hs_out, vs_out, blk_out, fld_out, fp_hold, blk_hold;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk2x = ~clk2x;

  vid_sync_timer #(
    .H_ACTIVE(8), .H_FP(2), .H_SYNC(3), .H_BP(3),
    .V_ACTIVE(4), .V_FP(1), .V_SYNC(2), .V_BP(2)
  ) dut (
    .clk2x, .rst_n, .slave_mode, .div4_mode,
    .pol_hs, .pol_vs, .pol_blk, .pol_fld,
    .ext_hs, .ext_vs, .ext_blk,
    .pix_en, .hs_out, .vs_out, .blk_out, .fld_out, .fp_hold, .blk_hold
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pix_tick();
    do @(negedge clk2x); while (pix_en !== 1'b1);
  endtask

  task automatic do_reset(input bit d4, input bit sl, input logic [3:0] p);
    @(negedge clk2x);
    rst_n = 1'b0;
    div4_mode = d4; slave_mode = sl;
    {pol_hs, pol_vs, pol_blk, pol_fld} = p;
    ext_hs = pol_hs; ext_vs = pol_vs; ext_blk = pol_blk;
    repeat (3) @(negedge clk2x);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(0, 0, 4'b0000);
    rst_n = 1'b0;
    @(negedge clk2x);
    chk("R2 outputs low in reset",
        int'({pix_en, hs_out, vs_out, blk_out, fld_out, fp_hold, blk_hold}), 0);
    {pol_hs, pol_vs, pol_blk, pol_fld} = 4'b1111;
    @(negedge clk2x);
    chk("R9 inverted inactive levels in reset", int'({hs_out, vs_out, blk_out, fld_out}), 15);
    rst_n = 1'b1;
  endtask

  task automatic t_clkdiv();
    int cnt;
    do_reset(0, 0, 4'b0000);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk2x); cnt += int'(pix_en); end
    chk("R1 div2 enables in 40 cycles", cnt, 20);
    do_reset(1, 0, 4'b0000);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk2x); cnt += int'(pix_en); end
    chk("R1 div4 enables in 40 cycles", cnt, 10);
  endtask

  task automatic t_master_h();
    int r[8]; int nr = 0; bit prev = 0; int hw = 0, nb = 0;
    do_reset(0, 0, 4'b0000);
    for (int t = 1; t <= 3 * HT; t++) begin
      pix_tick();
      if (hs_out && !prev && nr < 8) begin r[nr] = t; nr++; end
      prev = hs_out;
      if (t <= HT) begin hw += int'(hs_out); nb += int'(!blk_out); end
      ext_hs = ((t % 5) == 0);
      ext_vs = ((t % 7) == 0);
      ext_blk = 1'b1;
    end
    chk("R3 first hsync pixel", r[0], 11);
    chk("R3 line length", r[1] - r[0], HT);
    chk("R3 hsync width", hw, 3);
    chk("R4 ext inputs ignored, active pixels", nb, 8);
  endtask

  task automatic t_master_v();
    int r[8]; int f[8]; int nr = 0; bit prev = 0; int vw = 0, nb = 0;
    do_reset(0, 0, 4'b0000);
    for (int t = 1; t <= 400; t++) begin
      pix_tick();
      if (vs_out && !prev && nr < 8) begin r[nr] = t; f[nr] = int'(fld_out); nr++; end
      prev = vs_out;
      if (nr == 1) begin vw += int'(vs_out); nb += int'(!blk_out); end
    end
    chk("R4 first vsync pixel", r[0], 81);
    chk("R5 field even after first vsync", f[0], 1);
    chk("R4 even field length", r[1] - r[0], 9 * HT);
    chk("R5 field odd after second vsync", f[1], 0);
    chk("R4 odd field length", r[2] - r[1], 10 * HT);
    chk("R4 vsync width", vw, 2 * HT);
    chk("R3 active pixels per field", nb, 32);
  endtask

  task automatic t_slave_h(input int period, input bit pol, input int exp_fp, input string tag);
    int r[8]; int fpb[9]; int nr = 0; bit prev = 0; bit a;
    do_reset(0, 1, {pol, 3'b000});
    foreach (fpb[i]) fpb[i] = 0;
    for (int t = 1; t <= 3 + 5 * period; t++) begin
      pix_tick();
      a = hs_out ^ pol;
      if (a && !prev && nr < 8) begin r[nr] = t; nr++; end
      prev = a;
      if (fp_hold) fpb[nr]++;
      ext_hs = pol ^ ((t >= 3) && (((t - 3) % period) < 2));
    end
    chk({tag, " sync one pixel after edge"}, r[0], 4);
    chk({tag, " line follows ext period"}, r[3] - r[2], period);
    chk({tag, " front-porch hold pixels"}, fpb[3], exp_fp);
  endtask

  task automatic t_lead_only();
    int nr = 0; bit prev = 0; int fph = 0;
    do_reset(0, 1, 4'b0000);
    for (int t = 1; t <= 40; t++) begin
      pix_tick();
      if (hs_out && !prev) nr++;
      prev = hs_out;
      if (t == 40) fph = int'(fp_hold);
      ext_hs = (t >= 3);
    end
    chk("R10 single resync on held sync", nr, 1);
    chk("R10 waiting in front porch", fph, 1);
  endtask

  task automatic t_slave_v(input int nl, input int exp_hold, input string tag);
    int r[8]; int f[8]; int hb[9]; int nr = 0; bit prev = 0; int bad = 0;
    do_reset(0, 1, 4'b0000);
    foreach (hb[i]) hb[i] = 0;
    for (int t = 1; t <= 3 + 4 * nl * HT; t++) begin
      pix_tick();
      if (vs_out && !prev && nr < 8) begin r[nr] = t; f[nr] = int'(fld_out); nr++; end
      prev = vs_out;
      if (blk_hold) begin hb[nr]++; if (!blk_out) bad++; end
      ext_hs = (t >= 3) && (((t - 3) % HT) < 2);
      ext_vs = (t >= 3) && (((t - 3) % (nl * HT)) < 2);
    end
    chk({tag, " field follows ext period"}, r[2] - r[1], nl * HT);
    chk({tag, " blanking hold pixels"}, hb[2], exp_hold);
    chk("R5 slave field toggles per vsync", int'(f[1] != f[2]), 1);
    chk("R8 blank active during hold", bad, 0);
  endtask

  task automatic t_ext_blank();
    do_reset(0, 1, 4'b0000);
    pix_tick();
    ext_blk = 1'b1;
    pix_tick();
    chk("R11 ext blank forces blank", int'(blk_out), 1);
    ext_blk = 1'b0;
    pix_tick();
    chk("R11 ext blank released", int'(blk_out), 0);
    do_reset(0, 0, 4'b0000);
    pix_tick();
    ext_blk = 1'b1;
    pix_tick();
    chk("R4 ext blank ignored in master", int'(blk_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_clkdiv();
    t_master_h();
    t_master_v();
    t_slave_h(12, 1'b1, 0, "R6 early pol-inverted");
    t_slave_h(20, 1'b0, 4, "R7 late");
    t_lead_only();
    t_slave_v(7, 0, "R8 early");
    t_slave_v(12, 42, "R8 late");
    t_ext_blank();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule